// File: doc/BRIEF.md
# Cascaded Codec Frame-Sync Generator

This block produces the frame timing for the serial control and data port of an audio codec that can sit at the head of a daisy chain (master) or further down it (slave). A master clock is divided by four to form the shift clock. In master mode a slot counter spans one sampling period of 2·A·B shift clocks, where A and B are two divider values. A primary frame sync is issued at the start of every period. Every device hands a delayed copy of its own frame sync to the next device after a programmable number of shift clocks.

The word shifted in after each primary frame sync is decoded. If its two final bits are both 1, the device asks for a secondary exchange. A master then issues a second frame sync half a period after the primary one. A slave marks the next sync it receives as secondary. A flag output tells which kind the most recent sync was. An error flag warns when the last primary sync of the chain would land beyond half the period.

Top module: `fsg_frame_sync`

## Requirements
- R1: `sclk_o` is the master clock divided by four: high for 2 and low for 2 master clock cycles, and low during reset. All sync outputs change only on the master clock edge where `sclk_o` rises.
- R2: In master mode a primary frame sync falls on the first `sclk_o` rising edge after reset, and after that every 2·A·B shift clocks (8·A·B master clocks).
- R3: In master mode `fs_n_o` is active low for exactly one shift clock period (4 master clocks).
- R4: `fs_dly_n_o` falls Deff shift clocks after each falling edge of `fs_n_o` and stays low for one shift clock. Deff is the effective delay.
- R5: Deff equals `dly_i` when `dly_i` is 18 or more. Any value below 18 is raised to 18.
- R6: After each primary sync, `rx_din_i` is sampled on the next WORD_W (16) rising edges of `sclk_o`, most significant bit first. A request is latched when the last two bits sampled are both 1. Any sync event clears a latched request.
- R7: In master mode with a latched request, a secondary frame sync falls A·B shift clocks (4·A·B master clocks) after the primary one. `sec_o` is 1 from that fall until the next fall of `fs_n_o`.
- R8: If the last two bits of the word are not both 1, no secondary sync occurs. The next fall of `fs_n_o` is the following primary, and it has `sec_o` = 0.
- R9: In slave mode `fs_n_o` copies `fs_in_i` as sampled at each `sclk_o` rising edge. Each high-to-low transition sampled this way is one sync event. The event is secondary (`sec_o` = 1) when a request is latched, and primary otherwise.
- R10: `err_o` is 1 exactly when master mode is selected and `chain_len_i`·Deff ≥ A·B. It follows the configuration one master clock later.
- R11: During reset `fs_n_o` = 1, `fs_dly_n_o` = 1, `sec_o` = 0, `err_o` = 0 and `sclk_o` = 0.
- R12: `sec_o` changes only on a clock edge where `fs_n_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| is_master_i | input | 1 | 1 = chain head, 0 = slave |
| div_a_i | input | A_W | Divider A (1 or more) |
| div_b_i | input | B_W | Divider B (1 or more) |
| dly_i | input | DLY_W | Frame-sync delay in shift clocks |
| chain_len_i | input | CHAIN_W | Number of slaves behind the master |
| fs_in_i | input | 1 | Frame sync from upstream device (slave mode) |
| rx_din_i | input | 1 | Received serial control/data bit |
| sclk_o | output | 1 | Shift clock |
| fs_n_o | output | 1 | Frame sync, active low |
| fs_dly_n_o | output | 1 | Delayed frame sync to next device, active low |
| sec_o | output | 1 | 1 when the latest sync was secondary |
| err_o | output | 1 | Primary syncs of the chain overrun half the period |

## Verification
A slot counter that wraps at the wrong count shows up on `fs_n_o` as a wrong gap between falls, at the first wrap after reset. A stale or lost request bit shows on `fs_n_o` within half a period: a secondary fall appears, or an expected one is missing, and `sec_o` reads wrong at that same fall. A delay counter that loads the unclamped value or counts off by one shifts `fs_dly_n_o` by a multiple of four master clocks, at the first delayed sync after the fault. A divider phase error breaks the four-cycle rhythm of `sclk_o` within one shift period.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
package fsg_pkg;
    // Smallest legal frame-sync delay, in shift clocks
    localparam int unsigned MIN_DLY = 18;

    typedef enum logic {
        SYNC_PRI = 1'b0,
        SYNC_SEC = 1'b1
    } sync_kind_e;
endpackage

// File: rtl/fsg_clkdiv.sv
`timescale 1ns/1ps
module fsg_clkdiv (
    input  logic clk_i,
    input  logic rst_ni,
    output logic sclk_o,
    output logic tick_o
);
    typedef struct packed {
        logic [1:0] ph;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = st_q.ph + 2'd1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // shift clock high in phases 2 and 3; updates happen as it rises
    assign sclk_o = st_q.ph[1];
    assign tick_o = (st_q.ph == 2'd1);
endmodule

// File: rtl/fsg_sched.sv
`timescale 1ns/1ps
module fsg_sched #(
    parameter int unsigned AB_W   = 16,
    localparam int unsigned SLOT_W = AB_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              is_master_i,
    input  logic              fs_in_i,
    input  logic              req_i,
    input  logic [AB_W-1:0]   half_i,
    input  logic [SLOT_W-1:0] last_slot_i,
    output logic              sync_o,
    output fsg_pkg::sync_kind_e kind_o,
    output logic              prim_o,
    output logic              fs_n_o
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              first;
        logic              fs_n;
        logic              fin_prev;
    } sch_st_t;

    sch_st_t st_d, st_q;

    logic [SLOT_W-1:0] slot_nx;
    logic              m_pri, m_sec, s_evt, evt;
    fsg_pkg::sync_kind_e kind;

    always_comb begin
        slot_nx = (st_q.first || (st_q.slot >= last_slot_i)) ? '0
                                                             : st_q.slot + SLOT_W'(1);
        m_pri   = (slot_nx == '0);
        m_sec   = (slot_nx == {1'b0, half_i}) && req_i && !m_pri;
        s_evt   = !fs_in_i && st_q.fin_prev;
        evt     = is_master_i ? (m_pri || m_sec) : s_evt;
        if (is_master_i) kind = m_sec ? fsg_pkg::SYNC_SEC : fsg_pkg::SYNC_PRI;
        else             kind = req_i ? fsg_pkg::SYNC_SEC : fsg_pkg::SYNC_PRI;

        st_d = st_q;
        if (tick_i) begin
            st_d.slot     = slot_nx;
            st_d.first    = 1'b0;
            st_d.fin_prev = fs_in_i;
            st_d.fs_n     = is_master_i ? !evt : fs_in_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.slot     <= '0;
            st_q.first    <= 1'b1;
            st_q.fs_n     <= 1'b1;
            st_q.fin_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = tick_i && evt;
    assign kind_o = kind;
    assign prim_o = tick_i && evt && (kind == fsg_pkg::SYNC_PRI);
    assign fs_n_o = st_q.fs_n;
endmodule

// File: rtl/fsg_decode.sv
`timescale 1ns/1ps
module fsg_decode #(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic sync_i,
    input  logic prim_i,
    input  logic rx_i,
    output logic req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] bits_left;
        logic [1:0]       tail;
        logic             req;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (sync_i) begin
                st_d.req       = 1'b0;
                st_d.bits_left = prim_i ? CNT_W'(WORD_W) : '0;
            end else if (st_q.bits_left != '0) begin
                st_d.tail      = {st_q.tail[0], rx_i};
                st_d.bits_left = st_q.bits_left - CNT_W'(1);
                if (st_q.bits_left == CNT_W'(1))
                    st_d.req = st_q.tail[0] & rx_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign req_o = st_q.req;
endmodule

// File: rtl/fsg_delay.sv
`timescale 1ns/1ps
module fsg_delay #(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             sync_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             fs_dly_n_o
);
    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             fs_dly_n;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.fs_dly_n = !(st_q.cnt == DLY_W'(1));
            if (sync_i)                st_d.cnt = dly_i;
            else if (st_q.cnt != '0)   st_d.cnt = st_q.cnt - DLY_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt      <= '0;
            st_q.fs_dly_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fs_dly_n_o = st_q.fs_dly_n;
endmodule

// File: rtl/fsg_frame_sync.sv
`timescale 1ns/1ps
module fsg_frame_sync #(
    parameter int unsigned A_W     = 8,
    parameter int unsigned B_W     = 8,
    parameter int unsigned DLY_W   = 8,
    parameter int unsigned CHAIN_W = 4,
    parameter int unsigned WORD_W  = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               is_master_i,
    input  logic [A_W-1:0]     div_a_i,
    input  logic [B_W-1:0]     div_b_i,
    input  logic [DLY_W-1:0]   dly_i,
    input  logic [CHAIN_W-1:0] chain_len_i,
    input  logic               fs_in_i,
    input  logic               rx_din_i,
    output logic               sclk_o,
    output logic               fs_n_o,
    output logic               fs_dly_n_o,
    output logic               sec_o,
    output logic               err_o
);
    localparam int unsigned AB_W   = A_W + B_W;
    localparam int unsigned SLOT_W = AB_W + 1;
    localparam int unsigned CMP_W  = CHAIN_W + DLY_W + AB_W + 1;

    typedef struct packed {
        logic sec;
        logic err;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                tick, sync, prim, req;
    fsg_pkg::sync_kind_e kind;
    logic [AB_W-1:0]     ab;
    logic [SLOT_W-1:0]   last_slot;
    logic [DLY_W-1:0]    dly_eff;
    logic                overrun;

    always_comb begin
        ab        = AB_W'(div_a_i) * AB_W'(div_b_i);
        last_slot = {ab, 1'b0} - SLOT_W'(1);
        dly_eff   = (dly_i < DLY_W'(fsg_pkg::MIN_DLY)) ? DLY_W'(fsg_pkg::MIN_DLY) : dly_i;
        overrun   = (CMP_W'(chain_len_i) * CMP_W'(dly_eff)) >= CMP_W'(ab);

        st_d     = st_q;
        st_d.err = is_master_i && overrun;
        if (sync) st_d.sec = (kind == fsg_pkg::SYNC_SEC);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    fsg_clkdiv u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sclk_o (sclk_o),
        .tick_o (tick)
    );

    fsg_sched #(.AB_W(AB_W)) u_sched (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .is_master_i (is_master_i),
        .fs_in_i     (fs_in_i),
        .req_i       (req),
        .half_i      (ab),
        .last_slot_i (last_slot),
        .sync_o      (sync),
        .kind_o      (kind),
        .prim_o      (prim),
        .fs_n_o      (fs_n_o)
    );

    fsg_decode #(.WORD_W(WORD_W)) u_dec (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .sync_i (sync),
        .prim_i (prim),
        .rx_i   (rx_din_i),
        .req_o  (req)
    );

    fsg_delay #(.DLY_W(DLY_W)) u_dly (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .sync_i     (sync),
        .dly_i      (dly_eff),
        .fs_dly_n_o (fs_dly_n_o)
    );

    assign sec_o = st_q.sec;
    assign err_o = st_q.err;
endmodule

// File: rtl/fsg_chk.sv
`timescale 1ns/1ps
module fsg_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic is_master_i,
    input logic sclk_o,
    input logic fs_n_o,
    input logic fs_dly_n_o,
    input logic sec_o
);
    logic [7:0] gap_q;
    logic       fs_prev_q, sclk_prev_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gap_q       <= '0;
            fs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            fs_prev_q   <= fs_n_o;
            sclk_prev_q <= sclk_o;
            if (fs_prev_q && !fs_n_o)                          gap_q <= 8'd1;
            else if (sclk_o && !sclk_prev_q && gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
        end
    end

    // R1
    sclk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sclk_o) |=> sclk_o);
    // R1
    sclk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sclk_o) |=> !sclk_o);
    // R3
    fs_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_master_i && $fell(fs_n_o)) |-> ##3 !fs_n_o ##1 fs_n_o);
    // R4
    dly_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(fs_dly_n_o) |-> $rose(sclk_o));
    // R5
    dly_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(fs_dly_n_o) |-> (gap_q >= 8'(fsg_pkg::MIN_DLY)));
    // R12
    sec_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(fs_n_o) |-> $stable(sec_o));
endmodule

bind fsg_frame_sync fsg_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .is_master_i (is_master_i),
    .sclk_o      (sclk_o),
    .fs_n_o      (fs_n_o),
    .fs_dly_n_o  (fs_dly_n_o),
    .sec_o       (sec_o)
);

// File: tb/fsg_frame_sync_tb.sv
`timescale 1ns/1ps
module fsg_frame_sync_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1;
    logic [7:0] div_a = 8'd5, div_b = 8'd5, dly = 8'd20;
    logic [3:0] chain = 4'd0;
    logic       fs_in = 1'b1, rx = 1'b0;
    logic       sclk, fs_n, fs_dly_n, sec, err;

    int vectors = 0, fails = 0, cyc = 0;
    int nfall = 0, ndly = 0, t_fall = 0, t_prev = 0, fs_w = 0, dly_gap = 0;
    int sclk_rise = 0, sclk_per = 0, sclk_hi = 0;
    logic sec_at = 1'b0, fs_p = 1'b1, dly_p = 1'b1, sclk_p = 1'b0;

    always #4 clk = ~clk;

    fsg_frame_sync dut_i (
        .clk_i(clk), .rst_ni(rst_n), .is_master_i(is_master),
        .div_a_i(div_a), .div_b_i(div_b), .dly_i(dly), .chain_len_i(chain),
        .fs_in_i(fs_in), .rx_din_i(rx),
        .sclk_o(sclk), .fs_n_o(fs_n), .fs_dly_n_o(fs_dly_n), .sec_o(sec), .err_o(err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (fs_p && !fs_n) begin t_prev = t_fall; t_fall = cyc; nfall++; sec_at = sec; end
        if (!fs_p && fs_n)   fs_w = cyc - t_fall;
        if (dly_p && !fs_dly_n) begin dly_gap = cyc - t_fall; ndly++; end
        if (!sclk_p && sclk) begin sclk_per = cyc - sclk_rise; sclk_rise = cyc; end
        if (sclk_p && !sclk) sclk_hi = cyc - sclk_rise;
        fs_p = fs_n; dly_p = fs_dly_n; sclk_p = sclk;
    end

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int deff(int d); return (d < 18) ? 18 : d; endfunction
    function automatic int exp_err(bit m, int c, int d, int a, int b);
        return (m && (c * deff(d) >= a * b)) ? 1 : 0;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R11 fs_n",  int'(fs_n), 1);
        chk("R11 fs_dly", int'(fs_dly_n), 1);
        chk("R11 sec",   int'(sec), 0);
        chk("R11 err",   int'(err), 0);
        chk("R11 sclk",  int'(sclk), 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_fall();
        int n0 = nfall;
        wait (nfall != n0);
        #1;
    endtask

    task automatic cfg(bit m, int a, int b, int d, int c);
        is_master = m; div_a = 8'(a); div_b = 8'(b); dly = 8'(d); chain = 4'(c);
    endtask

    task automatic run_master(int a, int b, int d, int c);
        int d0;
        cfg(1'b1, a, b, d, c); rx = 1'b0; fs_in = 1'b1;
        do_reset();
        wait_fall();
        wait_fall();
        chk("R2 period", t_fall - t_prev, 8 * a * b);
        chk("R8 sec primary", int'(sec_at), 0);
        d0 = ndly;
        repeat (6) @(negedge clk);
        chk("R3 fs width", fs_w, 4);
        chk("R1 sclk period", sclk_per, 4);
        chk("R1 sclk high", sclk_hi, 2);
        wait (ndly != d0); #1;
        chk("R4 R5 delay gap", dly_gap, 4 * deff(d));
        chk("R10 err", int'(err), exp_err(1'b1, c, d, a, b));
    endtask

    task automatic run_master_req(int a, int b, int d);
        cfg(1'b1, a, b, d, 0); rx = 1'b1;
        do_reset();
        wait_fall();
        chk("R2 first primary", int'(sec_at), 0);
        wait_fall();
        chk("R7 secondary gap", t_fall - t_prev, 4 * a * b);
        chk("R7 sec flag set", int'(sec_at), 1);
        wait_fall();
        rx = 1'b0;
        chk("R7 back to primary", t_fall - t_prev, 4 * a * b);
        chk("R7 sec flag clear", int'(sec_at), 0);
        wait_fall();
        chk("R8 no request gap", t_fall - t_prev, 8 * a * b);
    endtask

    task automatic drive_word(logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            @(negedge sclk); #1 rx = w[i];
        end
        @(negedge sclk); #1 rx = 1'b0;
    endtask

    task automatic run_words(int a, int b, int d, int n);
        logic [15:0] w;
        bit          want;
        cfg(1'b1, a, b, d, 0); rx = 1'b0;
        do_reset();
        wait_fall();
        for (int k = 0; k < n; k++) begin
            w = 16'($urandom);
            if (k == 0) w[1:0] = 2'b11;
            if (k == 1) w[1:0] = 2'b10;
            if (k == 2) w[1:0] = 2'b01;
            want = (w[1:0] == 2'b11);
            drive_word(w);
            wait_fall();
            chk("R6 word gap", t_fall - t_prev, want ? 4 * a * b : 8 * a * b);
            chk("R6 word kind", int'(sec_at), int'(want));
            if (want) begin
                wait_fall();
                chk("R7 primary after secondary", int'(sec_at), 0);
            end
        end
    endtask

    task automatic pulse_fs();
        @(negedge sclk); #1 fs_in = 1'b0;
        @(negedge sclk); #1 fs_in = 1'b1;
    endtask

    task automatic run_slave(int d, bit with_req);
        int n0, d0;
        cfg(1'b0, 6, 6, d, 3); rx = with_req; fs_in = 1'b1;
        do_reset();
        repeat (8) @(negedge clk);
        chk("R10 slave err", int'(err), 0);
        n0 = nfall; d0 = ndly;
        pulse_fs();
        wait (nfall != n0); #1;
        chk("R9 slave first primary", int'(sec_at), 0);
        repeat (8) @(negedge clk);
        chk("R9 slave fs width", fs_w, 4);
        wait (ndly != d0); #1;
        chk("R4 slave delay gap", dly_gap, 4 * deff(d));
        repeat (30) @(negedge sclk);
        n0 = nfall;
        pulse_fs();
        wait (nfall != n0); #1;
        chk("R9 slave second kind", int'(sec_at), int'(with_req));
        rx = 1'b0;
        repeat (30) @(negedge sclk);
        n0 = nfall;
        pulse_fs();
        wait (nfall != n0); #1;
        chk("R9 slave third primary", int'(sec_at), 0);
    endtask

    initial begin
        wait (cyc >= 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // directed corners: clamp below, at and above the minimum; err boundary
        run_master(5, 5, 5, 1);
        run_master(6, 6, 17, 2);
        run_master(6, 6, 18, 2);
        run_master(6, 6, 19, 1);
        run_master(7, 5, 24, 0);
        for (int k = 0; k < 6; k++)
            run_master(5 + int'($urandom % 5), 5 + int'($urandom % 5),
                       int'($urandom % 25), int'($urandom % 4));
        run_master_req(5, 5, 20);
        run_master_req(7, 6, 3);
        run_words(6, 5, 18, 8);
        run_slave(20, 1'b1);
        run_slave(4, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule